// File: doc/BRIEF.md
# Status Reporting and Self-Timed Busy Controller

This block sits behind a serial flash command port and covers two jobs. It answers the status-read command by sending a status byte that repeats for as long as the host keeps clocking. It also decodes the program and erase commands, captures their page or block address, and runs a per-operation countdown while the device reports busy. The array cell operations are not modelled. Only the timing, the busy flag and the captured operation descriptor are produced.

The serial lines are sampled by a fast system clock. Input bits are taken on serial-clock rising edges and output bits change on falling edges, so the timing matches SPI mode 0. A timed operation starts on the rising edge of chip select, and only when a complete and legal command frame came before it. While busy, a neighbouring array engine reads the descriptor outputs (kind, buffer, page). The same neighbour reports page-to-buffer compare results through a one-cycle strobe.

Top module: `stat_busy_ctrl`

## Requirements
- R1: Opcode 57h or D7h selects status read. After the 8th opcode bit, the next serial-clock falling edge presents status bit 7, and each later falling edge presents the next lower bit, so bits go out MSB first and can be sampled on rising edges. `miso_oe_o` is 1 only while a status bit is being presented with chip select low.
- R2: After bit 0, the next falling edge restarts at bit 7. The compare bit is sampled again at the start of every pass.
- R3: Status bit 7 is 1 when ready and 0 when busy. It is taken live, so while the clock is paused on bit 7, `miso_o` follows `ready_o`.
- R4: Status bit 6 holds the `cmp_mismatch_i` value latched by the most recent `cmp_done_i` strobe (0 means match). Bits 5..3 are the fixed code 1,0,0. Bits 2..0 are driven 0.
- R5: After the opcode come 24 bits, MSB first: 3 reserved bits, a 12-bit page, then 9 ignored bits. The opcodes decode as follows: 83h is kind 0 on buffer 0, 86h is kind 0 on buffer 1, 88h is kind 1 on buffer 0, 89h is kind 1 on buffer 1, and 81h is kind 2. Kind 0 is erase-and-program, kind 1 is program only and kind 2 is page erase. `op_page_o` and `op_buf_o` carry the captured page and buffer.
- R6: Opcode 50h is block erase, kind 3. Its 24 bits are 3 reserved bits, a 9-bit block number, then 12 ignored bits. `op_page_o` becomes the block number times 8.
- R7: An operation starts only on the rising edge of chip select. `ready_o` falls on the clock edge after the one that samples chip select high. It stays low for exactly T_ERASE_PROG, T_PROG, T_PAGE_ERASE or T_BLOCK_ERASE cycles, according to the kind.
- R8: A program or erase command that arrives while busy is ignored, and the descriptor outputs do not change. Status read still works while busy.
- R9: A program or erase command is discarded if chip select rises before all 32 bits (opcode plus 24) have arrived.
- R10: After reset, `ready_o` is 1, `miso_oe_o` is 0 and the compare bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| cmp_done_i | input | 1 | One-cycle strobe when a compare finishes |
| cmp_mismatch_i | input | 1 | Compare result, 1 = mismatch |
| ready_o | output | 1 | 1 = idle, 0 = timed operation running |
| op_kind_o | output | 2 | Kind of the current or last operation (0..3) |
| op_buf_o | output | 1 | Buffer used by the program operation |
| op_page_o | output | PAGE_W | Page (or first page of the block) |

## Verification
The status byte is read in three ways: while idle, while busy (several passes in one frame) and with the clock frozen on bit 7. Together these separate a live ready bit from a snapshot and show whether the byte restarts correctly. Random program and erase frames with random pages across all six opcodes check each kind's duration, buffer select and address slicing. Directed cases cover a frame cut short by one bit, a command sent during a long block erase, and compare strobes of both polarities, which separate a discarded command from an accepted one and a latched compare bit from a live one.

// File: rtl/stat_busy_pkg.sv
package stat_busy_pkg;
  typedef enum logic [1:0] {
    OPK_ERPG   = 2'd0,
    OPK_PROG   = 2'd1,
    OPK_PERASE = 2'd2,
    OPK_BERASE = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic     is_op;
    op_kind_e kind;
    logic     buf_sel;
  } cmd_t;

  localparam logic [2:0] DENSITY_CODE = 3'b100;

  function automatic logic is_status(input logic [7:0] op);
    return (op == 8'h57) || (op == 8'hD7);
  endfunction

  function automatic cmd_t decode_cmd(input logic [7:0] op);
    cmd_t c;
    c.is_op   = 1'b1;
    c.kind    = OPK_ERPG;
    c.buf_sel = 1'b0;
    case (op)
      8'h83: ;
      8'h86: c.buf_sel = 1'b1;
      8'h88: c.kind = OPK_PROG;
      8'h89: begin c.kind = OPK_PROG; c.buf_sel = 1'b1; end
      8'h81: c.kind = OPK_PERASE;
      8'h50: c.kind = OPK_BERASE;
      default: c.is_op = 1'b0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/stat_spi_rx.sv
module stat_spi_rx #(
  parameter int FRAME_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csn_i,
  input  logic               sclk_i,
  input  logic               mosi_i,
  output logic               sck_fall_o,
  output logic               cs_rise_o,
  output logic               hdr_done_o,
  output logic               full_o,
  output logic [7:0]         opcode_o,
  output logic [FRAME_W-9:0] addr_o
);
  localparam int CW = $clog2(FRAME_W + 1);

  logic          sck_q, csn_q, sck_rise;
  logic [CW-1:0] cnt_q;

  assign sck_rise   = sclk_i & ~sck_q & ~csn_i;
  assign sck_fall_o = ~sclk_i & sck_q & ~csn_i;
  assign cs_rise_o  = csn_i & ~csn_q;
  assign hdr_done_o = cnt_q >= CW'(8);
  assign full_o     = cnt_q == CW'(FRAME_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      csn_q    <= 1'b1;
      cnt_q    <= '0;
      opcode_o <= '0;
      addr_o   <= '0;
    end else begin
      sck_q <= sclk_i;
      csn_q <= csn_i;
      if (csn_i) begin
        cnt_q <= '0;
      end else if (sck_rise && !full_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q < CW'(8)) opcode_o <= {opcode_o[6:0], mosi_i};
        else                addr_o   <= {addr_o[FRAME_W-10:0], mosi_i};
      end
    end
  end
endmodule

// File: rtl/stat_status_tx.sv
module stat_status_tx
  import stat_busy_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic sck_fall_i,
  input  logic ready_i,
  input  logic cmp_i,
  output logic miso_o,
  output logic oe_o
);
  logic       shown_q, cmp_snap_q;
  logic [2:0] idx_q;
  logic [7:0] byte_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shown_q    <= 1'b0;
      idx_q      <= 3'd7;
      cmp_snap_q <= 1'b0;
    end else if (!active_i) begin
      shown_q <= 1'b0;
      idx_q   <= 3'd7;
    end else if (sck_fall_i) begin
      shown_q <= 1'b1;
      if (!shown_q || idx_q == 3'd0) begin
        idx_q      <= 3'd7;
        cmp_snap_q <= cmp_i;   // re-sampled at each pass start
      end else begin
        idx_q <= idx_q - 3'd1;
      end
    end
  end

  // bit 7 is live so a paused clock tracks the busy state
  assign byte_w = {ready_i, cmp_snap_q, DENSITY_CODE, 3'b000};
  assign miso_o = shown_q ? byte_w[idx_q] : 1'b0;
  assign oe_o   = shown_q & active_i;
endmodule

// File: rtl/stat_busy_timer.sv
module stat_busy_timer
  import stat_busy_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int T_ERASE_PROG  = 120,
  parameter int T_PROG        = 80,
  parameter int T_PAGE_ERASE  = 60,
  parameter int T_BLOCK_ERASE = 400
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  op_kind_e kind_i,
  output logic     busy_o
);
  logic [CNT_W-1:0] cnt_q, load_w;

  always_comb begin
    case (kind_i)
      OPK_ERPG:   load_w = CNT_W'(T_ERASE_PROG - 1);
      OPK_PROG:   load_w = CNT_W'(T_PROG - 1);
      OPK_PERASE: load_w = CNT_W'(T_PAGE_ERASE - 1);
      default:    load_w = CNT_W'(T_BLOCK_ERASE - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= load_w;
      end
    end else if (cnt_q == '0) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/stat_busy_ctrl.sv
module stat_busy_ctrl
  import stat_busy_pkg::*;
#(
  parameter int PAGE_W        = 12,
  parameter int BYTE_W        = 9,
  parameter int RSV_W         = 3,
  parameter int BLK_LOG       = 3,
  parameter int CNT_W         = 16,
  parameter int T_ERASE_PROG  = 120,
  parameter int T_PROG        = 80,
  parameter int T_PAGE_ERASE  = 60,
  parameter int T_BLOCK_ERASE = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              cmp_done_i,
  input  logic              cmp_mismatch_i,
  output logic              ready_o,
  output logic [1:0]        op_kind_o,
  output logic              op_buf_o,
  output logic [PAGE_W-1:0] op_page_o
);
  localparam int ADDR_W  = RSV_W + PAGE_W + BYTE_W;
  localparam int FRAME_W = 8 + ADDR_W;
  localparam int BLK_W   = PAGE_W - BLK_LOG;
  localparam int T_MAX_A = (T_ERASE_PROG > T_PROG) ? T_ERASE_PROG : T_PROG;
  localparam int T_MAX_B = (T_PAGE_ERASE > T_BLOCK_ERASE) ? T_PAGE_ERASE : T_BLOCK_ERASE;
  localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;

  logic              sck_fall_w, cs_rise_w, hdr_done_w, full_w;
  logic [7:0]        opcode_w;
  logic [ADDR_W-1:0] addr_w;
  logic              busy_w, start_w, stat_active_w, cmp_q;
  cmd_t              cmd_w;
  logic [PAGE_W-1:0] page_w;

  stat_spi_rx #(.FRAME_W(FRAME_W)) rx_i (
    .clk_i, .rst_ni, .csn_i, .sclk_i, .mosi_i,
    .sck_fall_o(sck_fall_w), .cs_rise_o(cs_rise_w),
    .hdr_done_o(hdr_done_w), .full_o(full_w),
    .opcode_o(opcode_w), .addr_o(addr_w)
  );

  assign cmd_w   = decode_cmd(opcode_w);
  assign start_w = cs_rise_w & full_w & cmd_w.is_op & ~busy_w;
  assign page_w  = (cmd_w.kind == OPK_BERASE)
                 ? {addr_w[ADDR_W-RSV_W-1 -: BLK_W], {BLK_LOG{1'b0}}}
                 : addr_w[BYTE_W +: PAGE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_kind_o <= '0;
      op_buf_o  <= 1'b0;
      op_page_o <= '0;
      cmp_q     <= 1'b0;
    end else begin
      if (start_w) begin
        op_kind_o <= cmd_w.kind;
        op_buf_o  <= cmd_w.buf_sel;
        op_page_o <= page_w;
      end
      if (cmp_done_i) cmp_q <= cmp_mismatch_i;
    end
  end

  stat_busy_timer #(
    .CNT_W(CNT_W), .T_ERASE_PROG(T_ERASE_PROG), .T_PROG(T_PROG),
    .T_PAGE_ERASE(T_PAGE_ERASE), .T_BLOCK_ERASE(T_BLOCK_ERASE)
  ) timer_i (
    .clk_i, .rst_ni, .start_i(start_w), .kind_i(cmd_w.kind), .busy_o(busy_w)
  );

  assign ready_o       = ~busy_w;
  assign stat_active_w = ~csn_i & hdr_done_w & is_status(opcode_w);

  stat_status_tx tx_i (
    .clk_i, .rst_ni, .active_i(stat_active_w), .sck_fall_i(sck_fall_w),
    .ready_i(ready_o), .cmp_i(cmp_q), .miso_o, .oe_o(miso_oe_o)
  );
endmodule

// File: rtl/stat_busy_ctrl_chk.sv
module stat_busy_ctrl_chk #(
  parameter int PAGE_W = 12,
  parameter int T_MAX  = 400
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_i,
  input logic              ready_o,
  input logic              miso_oe_o,
  input logic [1:0]        op_kind_o,
  input logic [PAGE_W-1:0] op_page_o
);
  logic [31:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (ready_o) run_q <= '0;
    else              run_q <= run_q + 1;
  end

  AST_START_ON_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(csn_i)) else $error("start without cs rise"); // R7
  AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= T_MAX) else $error("busy too long"); // R7
  AST_DESC_STABLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> ($stable(op_page_o) && $stable(op_kind_o)))
    else $error("descriptor changed while busy"); // R8
  AST_BLOCK_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && op_kind_o == 2'd3) |-> (op_page_o[2:0] == 3'b000))
    else $error("block page misaligned"); // R6
  AST_OE_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> !csn_i) else $error("oe with cs high"); // R1
endmodule

bind stat_busy_ctrl stat_busy_ctrl_chk #(.PAGE_W(PAGE_W), .T_MAX(T_MAX)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_i(csn_i), .ready_o(ready_o),
  .miso_oe_o(miso_oe_o), .op_kind_o(op_kind_o), .op_page_o(op_page_o)
);

// File: tb/stat_busy_ctrl_tb_top.sv
module stat_busy_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_EP = 120, T_PG = 80, T_PE = 60, T_BE = 400;

  logic clk = 0, rst_n = 0, csn = 1, sclk = 0, mosi = 0;
  logic cmp_done = 0, cmp_mis = 0;
  logic miso, miso_oe, ready, op_buf;
  logic [1:0] op_kind;
  logic [11:0] op_page;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_busy_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .cmp_done_i(cmp_done),
    .cmp_mismatch_i(cmp_mis), .ready_o(ready), .op_kind_o(op_kind),
    .op_buf_o(op_buf), .op_page_o(op_page)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] opc(input int i);
    case (i) 0: return 8'h83; 1: return 8'h86; 2: return 8'h88;
             3: return 8'h89; 4: return 8'h81; default: return 8'h50; endcase
  endfunction
  function automatic int kind_of(input int i);
    return (i < 2) ? 0 : (i < 4) ? 1 : (i == 4) ? 2 : 3;
  endfunction
  function automatic int dur(input int k);
    return (k == 0) ? T_EP : (k == 1) ? T_PG : (k == 2) ? T_PE : T_BE;
  endfunction
  function automatic logic [7:0] exp_stat(input logic rdy, input logic c);
    return {rdy, c, 3'b100, 3'b000};
  endfunction
  function automatic logic [31:0] frame(input int i, input logic [11:0] pg);
    if (i == 5) return {opc(i), 3'b101, pg[11:3], 12'hABC};
    return {opc(i), 3'b010, pg, 9'h1F3};
  endfunction

  task automatic xbit(input logic b, output logic r);
    @(negedge clk); sclk = 0; mosi = b;
    @(negedge clk); r = miso;
    @(negedge clk); sclk = 1;
    @(negedge clk);
  endtask
  task automatic cs_lo(); @(negedge clk); csn = 0; endtask
  task automatic cs_hi(); @(negedge clk); sclk = 0; @(negedge clk); csn = 1; endtask

  task automatic send(input logic [31:0] f, input int n);
    logic r;
    cs_lo();
    for (int i = 0; i < n; i++) xbit(f[31-i], r);
    cs_hi();
  endtask

  task automatic read_stat(input int n, output logic [7:0] b [4]);
    logic r;
    cs_lo();
    for (int i = 7; i >= 0; i--) xbit(8'hD7 >> i, r);
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) begin xbit(1'b0, r); b[k][i] = r; end
    cs_hi();
  endtask

  task automatic busy_len(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!ready) n++;
      else if (n > 0) break;
      else if (i > 4) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] sb [4];
    logic [11:0] pg;
    int n, sel;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 ready", ready, 1);
    check("R10 oe", miso_oe, 0);

    // idle status, multiple passes
    read_stat(3, sb);
    check("R1 R4 R10 idle status", sb[0][7:3], exp_stat(1, 0) >> 3);
    check("R2 second pass", sb[1][7:3], exp_stat(1, 0) >> 3);
    check("R4 low bits", sb[2][2:0], 0);

    // compare bit
    @(negedge clk); cmp_done = 1; cmp_mis = 1; @(negedge clk); cmp_done = 0; cmp_mis = 0;
    read_stat(1, sb);
    check("R4 mismatch bit", sb[0][7:3], exp_stat(1, 1) >> 3);
    @(negedge clk); cmp_done = 1; @(negedge clk); cmp_done = 0;
    read_stat(1, sb);
    check("R4 match bit", sb[0][6], 0);

    // random program/erase commands
    for (int t = 0; t < 12; t++) begin
      sel = (t < 6) ? t : int'($urandom_range(0, 5));
      pg = 12'($urandom);
      send(frame(sel, pg), 32);
      busy_len(n);
      check("R7 duration", n, dur(kind_of(sel)));
      check("R5 kind", op_kind, kind_of(sel));
      if (sel < 4) check("R5 buffer", op_buf, sel % 2);
      if (sel == 5) check("R6 block page", op_page, {pg[11:3], 3'b000});
      else          check("R5 page", op_page, pg);
    end

    // short frame discarded
    send(frame(4, 12'h123), 31);
    busy_len(n);
    check("R9 short frame ignored", n, 0);
    check("R9 page unchanged", op_page == 12'h123, 0);

    // status while busy, then ignored command during busy
    send(frame(5, 12'h5A8), 32);
    read_stat(3, sb);
    check("R3 R8 busy bit", sb[0][7], 0);
    check("R2 busy repeat", sb[2][7:3], exp_stat(0, 0) >> 3);
    send(frame(4, 12'h0F1), 32);
    check("R8 ignored page", op_page, 12'h5A8);
    check("R8 ignored kind", op_kind, 3);
    // paused clock on bit 7
    begin
      logic r;
      cs_lo();
      for (int i = 7; i >= 0; i--) xbit(8'h57 >> i, r);
      @(negedge clk); sclk = 0;
      @(negedge clk); @(negedge clk);
      check("R3 paused busy", miso, 0);
      check("R1 oe on", miso_oe, 1);
      n = 0;
      while (!ready && n < 1000) begin @(negedge clk); n++; end
      check("R3 live ready", miso, 1);
      cs_hi();
      @(negedge clk);
      check("R1 oe off", miso_oe, 0);
    end
    busy_len(n);
    check("R8 no deferred start", n, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule